// File: doc/BRIEF.md
# Selectable BERT Pattern Generator

This block is the transmit half of a bit-error-rate tester on a line interface. It sends one test bit per enabled clock on a single serial output. A 4-bit mode code selects what is sent: a constant level, one of two short fixed repeating patterns, a loop of one to four user-programmed 8-bit words, or one of three maximal-length pseudo-random sequences with lengths 2^15-1, 2^20-1 and 2^23-1.

A pulse on the restart strobe, a change of the mode code, or reset puts the chosen sequence back to its first bit. Every shift register restarts from all ones, so none can lock up in the all-zero state. The user words are captured only on the restart strobe. The line rate is set by the bit-enable input. The serial output moves to the next bit only on cycles where bit-enable is high, and it holds its value on every other cycle.

Top module: `bert_pattern_gen`

## Requirements
- R1: Mode 1 drives a constant 0 and mode 2 drives a constant 1 on `data_out`.
- R2: Mode 3 sends 1,0,1,0,... and the first bit after a restart is 1, so ones density is exactly half.
- R3: Mode 4 sends 1,1,0,0,1,1,0,0,... and the first bit after a restart is 1.
- R4: Modes 5, 6, 7 and 8 loop over 1, 2, 3 or 4 user words, in this order: word 0 at `user_words[7:0]`, then word 1 at `[15:8]`, and so on. Each word is sent MSB first. The words are captured from `user_words` only at an edge where `restart` is high. At any other time a change on `user_words` has no effect on the output.
- R5: Mode 9 uses a 15-bit register s[14:0], shifted as s <= {s[13:0], s[14]^s[13]}. The output is the inverse of s[14]. The period is 32767 bits, the longest run of zeros is 15, and the first bit after a restart is 0.
- R6: Mode 10 uses a 20-bit register with feedback s[19]^s[2], shifted in at bit 0. The output is s[19], not inverted, and the first bit after a restart is 1.
- R7: Mode 11 uses a 23-bit register with feedback s[22]^s[17], shifted in at bit 0. The output is the inverse of s[22], and the first bit after a restart is 0.
- R8: `data_out` moves to the next bit of the sequence only at an edge where `bit_en` is high. At any other edge it keeps its value.
- R9: A `restart` pulse, or a change of `mode` at a clock edge, starts the selected sequence again from its first bit, with every shift register set to all ones. This takes priority over `bit_en`, and the first bit shows on the output after that edge.
- R10: The unused mode codes 0 and 12 to 15 drive `data_out` to 1.
- R11: A synchronous active-low reset clears the stored user words to zero and starts the current mode from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Advance the serial output by one bit at this edge |
| mode | input | 4 | Pattern select code |
| restart | input | 1 | Capture user words and restart the sequence |
| user_words | input | 32 | Four user words; word i at bits [8i+7:8i] |
| data_out | output | 1 | Serial test bit |

## Verification
The condition that is hardest to reach from the ports is the longest zero run of the 15-stage sequence. It occurs only once per 32767-bit period. To reach it, the bench runs mode 9 without a break for two full periods while it measures runs of zeros at the output. The bench also drives `bit_en` in an irregular on/off pattern during long pseudo-random runs. It changes the mode and the stored words in the middle of a sequence with and without the strobe, which shows that holding, restart priority and word capture all behave correctly at arbitrary positions.

// File: rtl/bert_pkg.sv
// Shared constants for the BERT pattern generator.
// Assumes the mode codes fixed by the block's requirements; the three
// pseudo-random generators are described by index 0..2 through functions.
package bert_pkg;

    localparam int MODE_W    = 4;
    localparam int PRBS_CNT  = 3;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MD_ZERO   = 4'd1;
    localparam mode_t MD_ONE    = 4'd2;
    localparam mode_t MD_ALT    = 4'd3;
    localparam mode_t MD_PAIR   = 4'd4;
    localparam mode_t MD_USER1  = 4'd5;
    localparam mode_t MD_USER4  = 4'd8;
    localparam mode_t MD_PRBS15 = 4'd9;
    localparam mode_t MD_PRBS20 = 4'd10;
    localparam mode_t MD_PRBS23 = 4'd11;

    // Register length of pseudo-random generator i
    function automatic int prbs_len(int i);
        case (i)
            0:       return 15;
            1:       return 20;
            default: return 23;
        endcase
    endfunction

    // Second feedback stage (1-based) of generator i
    function automatic int prbs_tap(int i);
        case (i)
            0:       return 14;
            1:       return 3;
            default: return 18;
        endcase
    endfunction

    // Whether generator i drives the line inverted
    function automatic bit prbs_inv(int i);
        case (i)
            0:       return 1'b1;
            1:       return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Mode code that selects generator i
    function automatic mode_t prbs_mode(int i);
        case (i)
            0:       return MD_PRBS15;
            1:       return MD_PRBS20;
            default: return MD_PRBS23;
        endcase
    endfunction

endpackage

// File: rtl/bert_lfsr.sv
// Fibonacci shift register for one pseudo-random sequence.
// Stage WIDTH and stage TAP are XORed together and shifted in at stage 1.
// The output is stage WIDTH, inverted when INVERT is set.
// Assumes the tap pair gives a maximal-length sequence. Seeding loads
// all ones, so the register can never hold the all-zero lock state.
module bert_lfsr #(
    parameter int WIDTH  = 15,
    parameter int TAP    = 14,
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed,
    input  logic adv,
    output logic bit_o
);

    logic [WIDTH-1:0] state;

    // Load the seed, or step the register once per advance request
    always_ff @(posedge clk) begin
        if (!rst_n || seed) begin
            state <= '1;
        end else if (adv) begin
            state <= {state[WIDTH-2:0], state[WIDTH-1] ^ state[TAP-1]};
        end
    end

    // Line bit taken from the last stage
    always_comb begin
        bit_o = state[WIDTH-1] ^ INVERT;
    end

    // R9
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (state == '1));

    // R5
    never_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed && !adv) |=> $stable(state));

endmodule

// File: rtl/bert_word_seq.sv
// Position counter, store for the user words, and bit select for the
// constant, fixed repeating and user-word modes.
// Assumes WORD_W and NUM_WORDS are powers of two. The counter then wraps
// on its own for the 2-bit and 4-bit fixed patterns, and the bit inside
// a word is picked by inverting the low counter bits, which sends MSB first.
module bert_word_seq
    import bert_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int NUM_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        seed,
    input  logic                        capture,
    input  logic                        adv,
    input  mode_t                       mode_sel,
    input  logic [NUM_WORDS*WORD_W-1:0] words_i,
    output logic                        bit_o
);

    localparam int TOTAL_BITS = NUM_WORDS * WORD_W;
    localparam int CNT_W      = $clog2(TOTAL_BITS);
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int SEL_W      = CNT_W - BIT_W;

    logic [CNT_W-1:0]                  pos_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0]  words_q;
    logic                              user_mode;
    logic [CNT_W-1:0]                  last_pos;
    logic [SEL_W-1:0]                  word_sel;
    logic [BIT_W-1:0]                  bit_sel;

    // Decode the user-word modes and the last position of their loop
    always_comb begin
        user_mode = (mode_sel >= MD_USER1) && (mode_sel <= MD_USER4);
        last_pos  = CNT_W'(((int'(mode_sel) - int'(MD_USER1) + 1) * WORD_W) - 1);
    end

    // Bit position inside the current pattern
    always_ff @(posedge clk) begin
        if (!rst_n || seed) begin
            pos_q <= '0;
        end else if (adv) begin
            if (user_mode && (pos_q == last_pos)) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // Store the user words on the restart strobe; reset clears them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
        end else if (capture) begin
            words_q <= words_i;
        end
    end

    // Split the position into the word number and the bit inside it (MSB first)
    always_comb begin
        word_sel = pos_q[CNT_W-1:BIT_W];
        bit_sel  = ~pos_q[BIT_W-1:0];
    end

    // Select the line bit for the non-random modes
    always_comb begin
        case (mode_sel)
            MD_ZERO: bit_o = 1'b0;
            MD_ONE:  bit_o = 1'b1;
            MD_ALT:  bit_o = ~pos_q[0];
            MD_PAIR: bit_o = ~pos_q[1];
            default: bit_o = user_mode ? words_q[word_sel][bit_sel] : 1'b1;
        endcase
    end

    // R4
    loop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |-> (pos_q <= last_pos));

    // R4
    words_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(words_q));

    // R8
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed && !adv) |=> $stable(pos_q));

endmodule

// File: rtl/bert_pattern_gen.sv
// Top of the selectable BERT pattern generator.
// It registers the mode code. A strobe or a change of mode reseeds every
// generator at the next edge, and that takes priority over bit_en. The
// output is a multiplexer fed only by registers, so data_out moves only
// at clock edges. Assumes bit_en is synchronous to clk.
module bert_pattern_gen
    import bert_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int NUM_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bit_en,
    input  logic [MODE_W-1:0]           mode,
    input  logic                        restart,
    input  logic [NUM_WORDS*WORD_W-1:0] user_words,
    output logic                        data_out
);

    mode_t                mode_q;
    logic                 restart_evt;
    logic                 step;
    logic                 word_bit;
    logic [PRBS_CNT-1:0]  prbs_bits;
    logic [PRBS_CNT-1:0]  prbs_hit;

    // Restart on the strobe or whenever the selected mode changes
    always_comb begin
        restart_evt = restart || (mode != mode_q);
        step        = bit_en && !restart_evt;
    end

    // Hold the mode that is being sent
    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    bert_word_seq #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed     (restart_evt),
        .capture  (restart),
        .adv      (step),
        .mode_sel (mode_q),
        .words_i  (user_words),
        .bit_o    (word_bit)
    );

    for (genvar g = 0; g < PRBS_CNT; g++) begin : g_prbs
        // Step only the generator that is currently selected
        always_comb begin
            prbs_hit[g] = (mode_q == prbs_mode(g));
        end

        bert_lfsr #(
            .WIDTH  (prbs_len(g)),
            .TAP    (prbs_tap(g)),
            .INVERT (prbs_inv(g))
        ) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .seed  (restart_evt),
            .adv   (step && prbs_hit[g]),
            .bit_o (prbs_bits[g])
        );
    end

    // Choose between the random generators and the word/fixed path
    always_comb begin
        data_out = word_bit;
        for (int i = 0; i < PRBS_CNT; i++) begin
            if (prbs_hit[i]) begin
                data_out = prbs_bits[i];
            end
        end
    end

    // R8
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !restart && (mode == mode_q)) |=> $stable(data_out));

    // R5
    prbs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prbs_hit));

endmodule

// File: tb/tb_bert_pattern_gen.sv
`timescale 1ns/1ps
module tb_bert_pattern_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [3:0]  mode = 4'd3;
    logic        restart = 1'b0;
    logic [31:0] user_words = 32'h0;
    logic        data_out;

    int checks = 0;
    int fails  = 0;

    bit    q_val[$];
    string q_tag[$];

    // bench reference state, built from the requirement text
    logic [14:0] m15;
    logic [19:0] m20;
    logic [22:0] m23;
    logic [7:0]  mw [4];
    logic [3:0]  mmode = 4'd0;
    int          pos = 0;

    bit track = 1'b0;
    int run_len = 0;
    int max_run = 0;

    localparam logic [31:0] WORDS_A = 32'h81F03CA5;
    localparam logic [31:0] WORDS_B = 32'h5A0FC37E;

    always #2.5 clk = ~clk;

    bert_pattern_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .mode       (mode),
        .restart    (restart),
        .user_words (user_words),
        .data_out   (data_out)
    );

    task automatic report_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic ref_seed();
        pos = 0;
        m15 = '1;
        m20 = '1;
        m23 = '1;
    endtask

    function automatic bit ref_bit();
        int n, k;
        case (mmode)
            4'd1: return 1'b0;
            4'd2: return 1'b1;
            4'd3: return (pos % 2) == 0;
            4'd4: return (pos % 4) < 2;
            4'd5, 4'd6, 4'd7, 4'd8: begin
                n = int'(mmode) - 4;
                k = pos % (8 * n);
                return mw[k / 8][7 - (k % 8)];
            end
            4'd9:  return ~m15[14];
            4'd10: return m20[19];
            4'd11: return ~m23[22];
            default: return 1'b1;
        endcase
    endfunction

    task automatic ref_edge(bit rst, bit rs, bit en, logic [3:0] md, logic [31:0] w);
        if (!rst) begin
            ref_seed();
            for (int i = 0; i < 4; i++) mw[i] = 8'h00;
            mmode = md;
        end else if (rs || (md != mmode)) begin
            ref_seed();
            if (rs) for (int i = 0; i < 4; i++) mw[i] = w[8*i +: 8];
            mmode = md;
        end else if (en) begin
            pos++;
            m15 = {m15[13:0], m15[14] ^ m15[13]};
            m20 = {m20[18:0], m20[19] ^ m20[2]};
            m23 = {m23[21:0], m23[22] ^ m23[17]};
        end
    endtask

    // driver: set inputs for the next edge and queue the bit expected after it
    task automatic cyc(bit rst, bit rs, bit en, logic [3:0] md, logic [31:0] w, string tag);
        @(posedge clk);
        #3;
        rst_n = rst;
        restart = rs;
        bit_en = en;
        mode = md;
        user_words = w;
        ref_edge(rst, rs, en, md, w);
        q_val.push_back(ref_bit());
        q_tag.push_back(tag);
    endtask

    // strobe once, then n-1 cycles; gapped selects an irregular bit_en
    task automatic run(int n, logic [3:0] md, logic [31:0] w, bit gapped, string tag);
        cyc(1'b1, 1'b1, 1'b1, md, w, tag);
        for (int i = 1; i < n; i++) begin
            cyc(1'b1, 1'b0, gapped ? ((i % 3) != 0) && ((i % 7) != 2) : 1'b1, md, w, tag);
        end
    endtask

    // monitor: compare one queued item per cycle, away from the edge
    always begin
        @(posedge clk);
        #2;
        if (q_val.size() > 0) begin
            bit    v;
            string t;
            v = q_val.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (data_out !== v) begin
                fails++;
                $display("FAIL %s: data_out=%b expected=%b at %0t", t, data_out, v, $time);
            end
            if (track) begin
                if (data_out == 1'b0) run_len++;
                else run_len = 0;
                if (run_len > max_run) max_run = run_len;
            end
        end
    end

    initial begin
        #(250000 * 5);
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        report_end();
    end

    initial begin
        // R11: reset state and first bit of mode 3, held while bit_en is low
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 4'd3, WORDS_A, "R11");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 4'd3, WORDS_A, "R11");
        // R11: stored words cleared by reset even though the inputs are nonzero
        for (int i = 0; i < 2; i++) cyc(1'b0, 1'b0, 1'b0, 4'd5, WORDS_A, "R11");
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b1, 4'd5, WORDS_A, "R11");

        // R1: constant levels
        run(10, 4'd1, WORDS_A, 1'b0, "R1");
        run(10, 4'd2, WORDS_A, 1'b0, "R1");
        // R2 and R3: fixed repeating patterns, also with gaps (R8)
        run(24, 4'd3, WORDS_A, 1'b0, "R2");
        run(40, 4'd4, WORDS_A, 1'b0, "R3");
        run(40, 4'd4, WORDS_A, 1'b1, "R8");

        // R4: one to four user words, MSB first, in order
        for (int m = 5; m <= 8; m++) run(80, 4'(m), WORDS_A, 1'b0, "R4");
        // R4: words changed without the strobe have no effect
        for (int i = 0; i < 70; i++) cyc(1'b1, 1'b0, 1'b1, 4'd8, WORDS_B, "R4");
        run(70, 4'd7, WORDS_B, 1'b1, "R4");

        // R8: irregular bit_en during a long random run
        run(400, 4'd10, WORDS_A, 1'b1, "R8");

        // R5: two full periods of the 15-stage sequence
        cyc(1'b1, 1'b1, 1'b1, 4'd9, WORDS_A, "R5");
        track = 1'b1;
        for (int i = 1; i < 2 * 32767 + 4; i++) cyc(1'b1, 1'b0, 1'b1, 4'd9, WORDS_A, "R5");
        repeat (3) @(posedge clk);
        track = 1'b0;
        checks++;
        if (max_run != 15) begin
            fails++;
            $display("FAIL R5: longest zero run=%0d expected=15", max_run);
        end

        // R6 and R7: the longer sequences
        run(3000, 4'd10, WORDS_A, 1'b0, "R6");
        run(3000, 4'd11, WORDS_A, 1'b0, "R7");

        // R9: mode change without strobe restarts, taking priority over bit_en
        run(37, 4'd11, WORDS_A, 1'b0, "R9");
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 1'b1, 4'd9, WORDS_A, "R9");
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 1'b1, 4'd4, WORDS_A, "R9");
        // R9: strobe in the middle of a sequence
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b1, 1'b1, 4'd10, WORDS_A, "R9");
            for (int j = 0; j < 25 + i; j++) cyc(1'b1, 1'b0, 1'b1, 4'd10, WORDS_A, "R9");
        end

        // R10: unused codes drive ones
        run(12, 4'd0, WORDS_A, 1'b0, "R10");
        run(12, 4'd12, WORDS_A, 1'b0, "R10");
        run(12, 4'd15, WORDS_A, 1'b1, "R10");

        cyc(1'b1, 1'b0, 1'b0, 4'd15, WORDS_A, "R10");
        repeat (4) @(posedge clk);
        report_end();
    end

endmodule